// File: doc/BRIEF.md
# Windowed RAM Address Counter

This block produces the write address for a display frame buffer. It keeps a column counter (5 bits, one step per byte) and a row counter (9 bits, one step per line). Both counters are held inside a rectangle that software sets with four boundary registers. Each data-byte strobe moves the address by one position. A 2-bit direction field chooses whether each axis counts up or down. A single axis bit chooses which axis moves first.

When the first-moving axis passes its boundary, it restarts at the opposite edge of the window, and the other axis takes one step. When that other axis also passes its boundary, it restarts in the same way. A long write stream therefore cycles through the window without end. The counters can also be loaded directly. A flat address, equal to row times the line width plus column, comes out next to the two counters.

Top module: `ram_addr_walker`

## Requirements
- R1: After reset the column and row counters are 0, the column window is 0..24, the row window is 0..299, the direction field is 2'b11 and the axis bit is 0. So 25 strobes from reset give column 0 and row 1.
- R2: Direction field bit 1 set makes the row count up, and clear makes it count down. Bit 0 does the same for the column (00 both down, 01 row down and column up, 10 row up and column down, 11 both up).
- R3: With the axis bit at 0 (`mode_ymajor`=0), each strobe moves the column. The row changes only when the column passes its boundary. With the axis bit at 1 the roles of row and column swap.
- R4: A primary axis that counts up and sits on its window end moves to the window start. A primary axis that counts down and sits on its window start moves to the window end. In both cases the secondary axis steps once in its own direction. A counter inside its window stays inside it.
- R5: When the secondary axis steps while it sits on its own boundary, it restarts at the opposite edge by the same rule, so both counters wrap in the same cycle.
- R6: `lin_addr` always equals `y_addr`*25 + `x_addr` and changes in the same cycle as the counters.
- R7: A direct load sets its counter on the next clock edge. A load has priority over a strobe in the same cycle, and that strobe's byte uses the address shown before the load.
- R8: A window or mode write takes effect from the following strobe. A strobe in the same cycle moves by the old settings.
- R9: With no strobe and no load, both counters hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| win_x_we | input | 1 | Write the column window bounds |
| win_x_lo | input | 5 | Column window start |
| win_x_hi | input | 5 | Column window end |
| win_y_we | input | 1 | Write the row window bounds |
| win_y_lo | input | 9 | Row window start |
| win_y_hi | input | 9 | Row window end |
| mode_we | input | 1 | Write direction field and axis bit |
| mode_dir | input | 2 | Direction field: bit 1 row up, bit 0 column up |
| mode_ymajor | input | 1 | Axis bit: 1 makes the row the primary axis |
| ld_x | input | 1 | Load the column counter |
| ld_x_val | input | 5 | Column load value |
| ld_y | input | 1 | Load the row counter |
| ld_y_val | input | 9 | Row load value |
| wr_stb | input | 1 | One data byte written: advance the address |
| x_addr | output | 5 | Current column address |
| y_addr | output | 9 | Current row address |
| lin_addr | output | 14 | Row times 25 plus column |

## Verification
The in-window assertion assumes three things: every window start is no greater than its end, every direct load lands inside the current window, and after a window change the counters are reloaded before they are relied on. The random stimulus draws each window as an ordered pair. Loads are drawn between the current bounds. Every window write is paired with same-cycle loads of both counters to the new window start. Directed cases then exercise wraps at single-position and two-position windows, and loads and setting changes that collide with a strobe.

// File: rtl/ram_walk_pkg.sv
package ram_walk_pkg;
   typedef enum logic [1:0] {
      DIR_YD_XD = 2'b00,
      DIR_YD_XI = 2'b01,
      DIR_YI_XD = 2'b10,
      DIR_YI_XI = 2'b11
   } walk_dir_e;

   localparam walk_dir_e DIR_RST = DIR_YI_XI;

   function automatic logic dir_x_up(walk_dir_e d);
      return d[0];
   endfunction

   function automatic logic dir_y_up(walk_dir_e d);
      return d[1];
   endfunction
endpackage

// File: rtl/walk_cfg_regs.sv
module walk_cfg_regs
   import ram_walk_pkg::*;
#(
   parameter int XW     = 5,
   parameter int YW     = 9,
   parameter int XS_RST = 0,
   parameter int XE_RST = 24,
   parameter int YS_RST = 0,
   parameter int YE_RST = 299
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          win_x_we,
   input  logic [XW-1:0] win_x_lo,
   input  logic [XW-1:0] win_x_hi,
   input  logic          win_y_we,
   input  logic [YW-1:0] win_y_lo,
   input  logic [YW-1:0] win_y_hi,
   input  logic          mode_we,
   input  logic [1:0]    mode_dir,
   input  logic          mode_ymajor,
   output logic [XW-1:0] xs,
   output logic [XW-1:0] xe,
   output logic [YW-1:0] ys,
   output logic [YW-1:0] ye,
   output logic          x_up,
   output logic          y_up,
   output logic          ymaj
);
   walk_dir_e dir_q;
   logic      ymaj_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         xs <= XW'(XS_RST);
         xe <= XW'(XE_RST);
      end else if (win_x_we) begin
         xs <= win_x_lo;
         xe <= win_x_hi;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ys <= YW'(YS_RST);
         ye <= YW'(YE_RST);
      end else if (win_y_we) begin
         ys <= win_y_lo;
         ye <= win_y_hi;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dir_q  <= DIR_RST;
         ymaj_q <= 1'b0;
      end else if (mode_we) begin
         dir_q  <= walk_dir_e'(mode_dir);
         ymaj_q <= mode_ymajor;
      end
   end

   assign x_up = dir_x_up(dir_q);
   assign y_up = dir_y_up(dir_q);
   assign ymaj = ymaj_q;

   p_mode_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
      mode_we |=> (ymaj == $past(mode_ymajor)) && ({y_up, x_up} == $past(mode_dir)));
endmodule

// File: rtl/walk_axis_step.sv
module walk_axis_step #(
   parameter int W = 5
) (
   input  logic [W-1:0] cur,
   input  logic [W-1:0] lo,
   input  logic [W-1:0] hi,
   input  logic         up,
   output logic         at_bnd,
   output logic [W-1:0] stepped
);
   always_comb begin
      at_bnd = up ? (cur == hi) : (cur == lo);
      if (at_bnd)
         stepped = up ? lo : hi;
      else if (up)
         stepped = cur + W'(1);
      else
         stepped = cur - W'(1);
   end
endmodule

// File: rtl/walk_lin_calc.sv
module walk_lin_calc #(
   parameter int XW         = 5,
   parameter int YW         = 9,
   parameter int LW         = 14,
   parameter int LINE_BYTES = 25,
   parameter bit MULT_STYLE = 1'b0
) (
   input  logic [XW-1:0] x,
   input  logic [YW-1:0] y,
   output logic [LW-1:0] lin
);
   localparam int MB = $clog2(LINE_BYTES + 1);
   localparam logic [MB-1:0] LB_VEC = MB'(LINE_BYTES);

   generate
      if (MULT_STYLE) begin : g_mult
         assign lin = LW'(y) * LW'(LINE_BYTES) + LW'(x);
      end else begin : g_shift_add
         always_comb begin
            lin = LW'(x);
            for (int i = 0; i < MB; i++) begin
               if (LB_VEC[i])
                  lin = lin + (LW'(y) << i);
            end
         end
      end
   endgenerate
endmodule

// File: rtl/ram_addr_walker.sv
module ram_addr_walker
   import ram_walk_pkg::*;
#(
   parameter int XW         = 5,
   parameter int YW         = 9,
   parameter int LINE_BYTES = 25,
   parameter int XS_RST     = 0,
   parameter int XE_RST     = 24,
   parameter int YS_RST     = 0,
   parameter int YE_RST     = 299,
   parameter bit MULT_STYLE = 1'b0,
   localparam int LW = $clog2((2**YW - 1) * LINE_BYTES + 2**XW)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          win_x_we,
   input  logic [XW-1:0] win_x_lo,
   input  logic [XW-1:0] win_x_hi,
   input  logic          win_y_we,
   input  logic [YW-1:0] win_y_lo,
   input  logic [YW-1:0] win_y_hi,
   input  logic          mode_we,
   input  logic [1:0]    mode_dir,
   input  logic          mode_ymajor,
   input  logic          ld_x,
   input  logic [XW-1:0] ld_x_val,
   input  logic          ld_y,
   input  logic [YW-1:0] ld_y_val,
   input  logic          wr_stb,
   output logic [XW-1:0] x_addr,
   output logic [YW-1:0] y_addr,
   output logic [LW-1:0] lin_addr
);
   generate
      if (XW < 1 || YW < 1) begin : g_bad_width
         $error("ram_addr_walker: counter widths must be positive");
      end
      if (LINE_BYTES < 1 || LINE_BYTES > 2**XW) begin : g_bad_line
         $error("ram_addr_walker: LINE_BYTES must lie in 1..2**XW");
      end
      if (XS_RST > XE_RST || XE_RST >= 2**XW) begin : g_bad_xrst
         $error("ram_addr_walker: column window reset values out of range");
      end
      if (YS_RST > YE_RST || YE_RST >= 2**YW) begin : g_bad_yrst
         $error("ram_addr_walker: row window reset values out of range");
      end
   endgenerate

   logic [XW-1:0] xs, xe, x_q, x_step;
   logic [YW-1:0] ys, ye, y_q, y_step;
   logic          x_up, y_up, ymaj;
   logic          x_bnd, y_bnd, x_en, y_en;

   walk_cfg_regs #(
      .XW(XW), .YW(YW),
      .XS_RST(XS_RST), .XE_RST(XE_RST), .YS_RST(YS_RST), .YE_RST(YE_RST)
   ) u_cfg (
      .clk(clk), .rst_n(rst_n),
      .win_x_we(win_x_we), .win_x_lo(win_x_lo), .win_x_hi(win_x_hi),
      .win_y_we(win_y_we), .win_y_lo(win_y_lo), .win_y_hi(win_y_hi),
      .mode_we(mode_we), .mode_dir(mode_dir), .mode_ymajor(mode_ymajor),
      .xs(xs), .xe(xe), .ys(ys), .ye(ye),
      .x_up(x_up), .y_up(y_up), .ymaj(ymaj)
   );

   walk_axis_step #(.W(XW)) u_xstep (
      .cur(x_q), .lo(xs), .hi(xe), .up(x_up), .at_bnd(x_bnd), .stepped(x_step)
   );

   walk_axis_step #(.W(YW)) u_ystep (
      .cur(y_q), .lo(ys), .hi(ye), .up(y_up), .at_bnd(y_bnd), .stepped(y_step)
   );

   // primary axis moves on every strobe; secondary only on primary wrap
   assign x_en = wr_stb && (!ymaj || y_bnd);
   assign y_en = wr_stb && (ymaj || x_bnd);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         x_q <= '0;
      else if (ld_x)
         x_q <= ld_x_val;
      else if (x_en)
         x_q <= x_step;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         y_q <= '0;
      else if (ld_y)
         y_q <= ld_y_val;
      else if (y_en)
         y_q <= y_step;
   end

   assign x_addr = x_q;
   assign y_addr = y_q;

   walk_lin_calc #(
      .XW(XW), .YW(YW), .LW(LW), .LINE_BYTES(LINE_BYTES), .MULT_STYLE(MULT_STYLE)
   ) u_lin (
      .x(x_q), .y(y_q), .lin(lin_addr)
   );

   logic x_in_win, y_in_win;
   assign x_in_win = (x_q >= xs) && (x_q <= xe);
   assign y_in_win = (y_q >= ys) && (y_q <= ye);

   p_x_in_win_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!win_x_we && !ld_x && x_in_win) |=> x_in_win);

   p_y_in_win_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!win_y_we && !ld_y && y_in_win) |=> y_in_win);

   p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_stb && !ld_x && !ld_y) |=> ($stable(x_addr) && $stable(y_addr)));

   p_load_x_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ld_x |=> (x_addr == $past(ld_x_val)));

   p_load_y_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ld_y |=> (y_addr == $past(ld_y_val)));

   p_row_waits_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_stb && !ld_y && !ymaj && !x_bnd) |=> $stable(y_addr));

   p_col_waits_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_stb && !ld_x && ymaj && !y_bnd) |=> $stable(x_addr));
endmodule

// File: tb/ram_addr_walker_tb.sv
`timescale 1ns/1ps
module ram_addr_walker_tb;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       win_x_we = 0, win_y_we = 0, mode_we = 0, mode_ymajor = 0;
   logic [4:0] win_x_lo = 0, win_x_hi = 0, ld_x_val = 0;
   logic [8:0] win_y_lo = 0, win_y_hi = 0, ld_y_val = 0;
   logic [1:0] mode_dir = 0;
   logic       ld_x = 0, ld_y = 0, wr_stb = 0;
   logic [4:0] x_addr;
   logic [8:0] y_addr;
   logic [13:0] lin_addr;

   int checks = 0;
   int failures = 0;

   // reference state
   int mx, my, mxs, mxe, mys, mye, mdir, mym;

   always #10 clk = ~clk;

   ram_addr_walker u_dut (
      .clk(clk), .rst_n(rst_n),
      .win_x_we(win_x_we), .win_x_lo(win_x_lo), .win_x_hi(win_x_hi),
      .win_y_we(win_y_we), .win_y_lo(win_y_lo), .win_y_hi(win_y_hi),
      .mode_we(mode_we), .mode_dir(mode_dir), .mode_ymajor(mode_ymajor),
      .ld_x(ld_x), .ld_x_val(ld_x_val), .ld_y(ld_y), .ld_y_val(ld_y_val),
      .wr_stb(wr_stb),
      .x_addr(x_addr), .y_addr(y_addr), .lin_addr(lin_addr)
   );

   task automatic chk(string tag, int act, int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic cmp_all(string tag);
      chk({tag, " x"}, int'(x_addr), mx);
      chk({tag, " y"}, int'(y_addr), my);
      chk({tag, " lin R6"}, int'(lin_addr), my * 25 + mx);
   endtask

   task automatic model_reset();
      mx = 0; my = 0; mxs = 0; mxe = 24; mys = 0; mye = 299; mdir = 3; mym = 0;
   endtask

   // one axis step, derived from R2/R4/R5
   function automatic int ax_next(int v, int lo, int hi, int up, int mask);
      if (up != 0) return (v == hi) ? lo : ((v + 1) & mask);
      return (v == lo) ? hi : ((v - 1) & mask);
   endfunction

   function automatic bit ax_bnd(int v, int lo, int hi, int up);
      return (up != 0) ? (v == hi) : (v == lo);
   endfunction

   task automatic model_update();
      int nx = mx;
      int ny = my;
      int xu = mdir & 1;
      int yu = (mdir >> 1) & 1;
      if (wr_stb) begin
         if (mym == 0) begin
            nx = ax_next(mx, mxs, mxe, xu, 31);
            if (ax_bnd(mx, mxs, mxe, xu)) ny = ax_next(my, mys, mye, yu, 511);
         end else begin
            ny = ax_next(my, mys, mye, yu, 511);
            if (ax_bnd(my, mys, mye, yu)) nx = ax_next(mx, mxs, mxe, xu, 31);
         end
      end
      if (ld_x) nx = ld_x_val;
      if (ld_y) ny = ld_y_val;
      mx = nx; my = ny;
      if (win_x_we) begin mxs = win_x_lo; mxe = win_x_hi; end
      if (win_y_we) begin mys = win_y_lo; mye = win_y_hi; end
      if (mode_we) begin mdir = mode_dir; mym = mode_ymajor; end
   endtask

   task automatic idle();
      win_x_we = 0; win_y_we = 0; mode_we = 0; ld_x = 0; ld_y = 0; wr_stb = 0;
   endtask

   task automatic tick(string tag);
      @(posedge clk);
      #1 model_update();
      @(negedge clk);
      cmp_all(tag);
      idle();
   endtask

   task automatic set_win(int xl, int xh, int yl, int yh);
      win_x_we = 1; win_x_lo = 5'(xl); win_x_hi = 5'(xh);
      win_y_we = 1; win_y_lo = 9'(yl); win_y_hi = 9'(yh);
      ld_x = 1; ld_x_val = 5'(xl); ld_y = 1; ld_y_val = 9'(yl);
   endtask

   task automatic set_mode(int d, int ym);
      mode_we = 1; mode_dir = 2'(d); mode_ymajor = ym[0];
   endtask

   task automatic load_xy(int x, int y);
      ld_x = 1; ld_x_val = 5'(x); ld_y = 1; ld_y_val = 9'(y);
   endtask

   initial begin
      #(20 * 150000);
      failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      void'($urandom(32'h1d2c3b4a));
      model_reset();
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // R1: reset state
      chk("R1 reset x", int'(x_addr), 0);
      chk("R1 reset y", int'(y_addr), 0);
      chk("R1 reset lin", int'(lin_addr), 0);

      // R1/R4: default window, 25 strobes reach the next row
      for (int i = 0; i < 25; i++) begin wr_stb = 1; tick("R1 walk"); end
      chk("R1 R4 row after 25", int'(y_addr), 1);
      chk("R1 R4 col after 25", int'(x_addr), 0);
      chk("R6 lin row1", int'(lin_addr), 25);

      // R9: hold without strobe
      tick("R9 idle");
      chk("R9 hold x", int'(x_addr), 0);

      // R2: each direction code from (10,100)
      for (int d = 0; d < 4; d++) begin
         set_mode(d, 0); load_xy(10, 100); tick("R2 setup");
         wr_stb = 1; tick("R2 step");
         chk("R2 col dir", int'(x_addr), (d & 1) ? 11 : 9);
         chk("R2 row still", int'(y_addr), 100);
      end

      // R3: row-major, column waits
      set_mode(3, 1); load_xy(4, 7); tick("R3 setup");
      wr_stb = 1; tick("R3 step");
      chk("R3 row moves", int'(y_addr), 8);
      chk("R3 col waits", int'(x_addr), 4);

      // R4/R5: tiny window, both wrap together, column-major up
      set_win(2, 3, 4, 5); set_mode(3, 0); tick("R4 win");
      load_xy(3, 5); tick("R5 setup");
      wr_stb = 1; tick("R5 double wrap");
      chk("R5 col wrap", int'(x_addr), 2);
      chk("R5 row wrap", int'(y_addr), 4);
      // down directions, row-major: start edges wrap to ends
      set_mode(0, 1); load_xy(2, 4); tick("R5 setup dn");
      wr_stb = 1; tick("R5 dn wrap");
      chk("R5 dn row", int'(y_addr), 5);
      chk("R5 dn col", int'(x_addr), 3);
      // single-position window on the primary axis
      set_win(6, 6, 10, 12); set_mode(3, 0); tick("R4 one");
      wr_stb = 1; tick("R4 single col");
      chk("R4 single col stays", int'(x_addr), 6);
      chk("R4 single row steps", int'(y_addr), 11);

      // R7: load collides with a strobe
      wr_stb = 1; ld_x = 1; ld_x_val = 5'd6; ld_y = 1; ld_y_val = 9'd12; tick("R7 collide");
      chk("R7 load wins y", int'(y_addr), 12);

      // R8: mode change with a strobe uses old mode
      set_win(0, 24, 0, 299); tick("R8 win");
      load_xy(5, 50); tick("R8 setup");
      set_mode(0, 1); wr_stb = 1; tick("R8 collide");
      chk("R8 old mode x", int'(x_addr), 6);
      chk("R8 old mode y", int'(y_addr), 50);
      wr_stb = 1; tick("R8 new mode");
      chk("R8 new mode y", int'(y_addr), 49);

      // random phase
      for (int n = 0; n < 4000; n++) begin
         int r = int'($urandom % 100);
         wr_stb = ($urandom % 10) < 7;
         if (r < 3) begin
            int a = int'($urandom % 32), b = int'($urandom % 32);
            int c = int'($urandom % 512), e = int'($urandom % 512);
            if (($urandom % 4) == 0) begin b = a; end
            set_win(a < b ? a : b, a < b ? b : a, c < e ? c : e, c < e ? e : c);
         end else begin
            if (r < 6) set_mode(int'($urandom % 4), int'($urandom % 2));
            if (r >= 6 && r < 9) begin
               ld_x = 1; ld_x_val = 5'(mxs + int'($urandom % (mxe - mxs + 1)));
            end
            if (r >= 9 && r < 12) begin
               ld_y = 1; ld_y_val = 9'(mys + int'($urandom % (mye - mys + 1)));
            end
         end
         tick("R4 R5 random");
      end

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule